// File: doc/BRIEF.md
# MSI Snooping Line-State Controller

This block keeps the coherence state of a small direct-indexed set of cache lines for one processor on a shared snooping bus. Each line is Invalid, Shared (readable) or Modified (readable and writable). Four transient states cover the time between a processor request that needs the bus and the arrival of the bus grant:

- pending read from Invalid
- pending read-exclusive from Invalid
- pending upgrade from Shared
- pending writeback from Modified

Snooped bus reads and read-exclusives are served in every state, including while the controller's own operation is waiting.

Processor requests (read, write, replace) enter with an index and are stalled through `cpu_ready` while an operation is pending. The block holds at most one pending operation, and it raises `bus_req` with a command code while one is held. Every change of a line's stable view (Invalid, Shared or Modified) produces a one-cycle transition record. The record gives the index, the initial and final stable state, the event that caused the change and the action taken, so an external checker can compare them against a simple reference protocol.

Each cycle the controller handles one event at most. A snoop comes first. A grant to the pending line comes next, and it is only considered when no snoop is present. An accepted processor request comes last.

The named transitions are:

- **FILL_S**: Invalid goes to pending read, and on grant to Shared.
- **FILL_M**: Invalid goes to pending read-exclusive, and on grant to Modified.
- **UPGRADE**: Shared goes to pending upgrade, and on grant to Modified.
- **UPG_LOST**: a snooped read-exclusive turns a pending upgrade into a pending read-exclusive from Invalid.
- **EVICT_M**: Modified goes to pending writeback, and on grant to Invalid.
- **EVICT_SNOOPED**: any snoop during a pending writeback supplies the data and ends in Invalid with no writeback.
- **DROP_S**: a replace or a snooped read-exclusive takes Shared to Invalid.
- **DEMOTE**: a snooped read takes Modified to Shared with data supply.
- **KILL_M**: a snooped read-exclusive takes Modified to Invalid with data supply.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req`, `rec_valid` and `snp_supply` are low and `cpu_ready` is high.
- R2: A processor read (`cpu_op`=0) to an Invalid line raises `bus_req` on the next cycle with `bus_cmd`=1 (bus read) and `bus_idx` equal to the index. A grant then gives a record with from=0 (Invalid), to=1 (Shared), event=1 (processor read) and action=1, and `bus_req` falls in the same cycle as the record.
- R3: A processor write (`cpu_op`=1) to an Invalid line requests `bus_cmd`=2 (read-exclusive). On grant it records from=0, to=2 (Modified), event=2 (processor write) and action=2.
- R4: A processor write to a Shared line requests `bus_cmd`=2. On grant it records from=1, to=2, event=2 and action=2.
- R5: A snooped read-exclusive (`snp_op`=1) to a line with a pending upgrade records from=1, to=0, event=5 and action=0, and keeps the request with `bus_cmd`=2. The later grant records from=0, to=2. A snooped read (`snp_op`=0) to that line changes nothing.
- R6: A replace (`cpu_op`=2) of a Modified line requests `bus_cmd`=3 (writeback). On grant it records from=2, to=0, event=3 and action=3.
- R7: Any snoop to a line with a pending writeback records from=2, to=0, with event=4 or 5 and action=4 (data supply). It pulses `snp_supply`, clears `bus_req`, and leaves no writeback, so a later grant records nothing.
- R8: A replace of a Shared line records from=1, to=0, event=3 and action=0 with no bus request. A snooped read-exclusive to a Shared line records from=1, to=0, event=5 and action=0.
- R9: A snooped read to a Modified line records from=2, to=1, event=4 and action=4. A snooped read-exclusive to it records from=2, to=0, event=5 and action=4. Both pulse `snp_supply` with the record.
- R10: Processor hits (a read in Shared or Modified, a write in Modified), snoops to Invalid lines and snoops to a line with a pending fill from Invalid produce no record and no change in the request.
- R11: `cpu_ready` is low while a request is pending or `snp_valid` is high. A processor request presented while `cpu_ready` is low is not taken, and the pending request's index and command stay unchanged.
- R12: In a cycle with `snp_valid` high, `bus_gnt` is ignored, and the pending request stays until a later grant.
- R13: Records are registered one cycle after the causing event. `rec_valid` lasts one cycle per stable-state change, and the initial and final states always differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 read, 1 write, 2 replace, 3 ignored |
| cpu_idx | input | IDX_W | Line index of processor request |
| cpu_ready | output | 1 | Processor request may be taken this cycle |
| snp_valid | input | 1 | Snooped bus request present |
| snp_op | input | 1 | 0 bus read, 1 bus read-exclusive |
| snp_idx | input | IDX_W | Line index of snoop |
| snp_supply | output | 1 | Data supplied for a snoop (with its record) |
| bus_gnt | input | 1 | Grant for the pending request |
| bus_req | output | 1 | A bus operation is pending |
| bus_cmd | output | 3 | 1 read, 2 read-exclusive, 3 writeback, 0 none |
| bus_idx | output | IDX_W | Line index of the pending operation |
| rec_valid | output | 1 | Transition record valid |
| rec_idx | output | IDX_W | Record line index |
| rec_from | output | 2 | Initial stable state (0 I, 1 S, 2 M) |
| rec_to | output | 2 | Final stable state |
| rec_event | output | 3 | 1 cpu read, 2 cpu write, 3 replace, 4 snoop read, 5 snoop read-exclusive |
| rec_act | output | 3 | 0 none, 1 bus read, 2 bus read-exclusive, 3 writeback, 4 data supply |

## Verification
The assertions check the following relations on every cycle:

- the stall while a request is pending;
- the stability of a waiting request;
- that a grant completes with a record whose action matches the command that was requested;
- that no bus-side completion is recorded in a snoop cycle;
- that data supply only comes from a Modified line;
- that every record is a real stable-state change.

Only the bench's scenarios can show that each named transition reaches the right final state and event code. This includes the race paths: an upgrade lost to a snooped read-exclusive, and a writeback cancelled by a snoop. The bench also shows that hits and snoops to Invalid lines leave no trace.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [2:0] {
        LS_I      = 3'd0,
        LS_S      = 3'd1,
        LS_M      = 3'd2,
        LS_PRD_I  = 3'd3,
        LS_PRDX_I = 3'd4,
        LS_PRDX_S = 3'd5,
        LS_PWB_M  = 3'd6
    } line_st_t;

    typedef enum logic [1:0] {
        AR_I = 2'd0,
        AR_S = 2'd1,
        AR_M = 2'd2
    } arch_t;

    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_CPU_RD  = 3'd1,
        EV_CPU_WR  = 3'd2,
        EV_CPU_REP = 3'd3,
        EV_SNP_RD  = 3'd4,
        EV_SNP_RDX = 3'd5,
        EV_GNT     = 3'd6
    } ev_t;

    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_BUS_RD = 3'd1,
        ACT_RDX    = 3'd2,
        ACT_WB     = 3'd3,
        ACT_SUPPLY = 3'd4
    } act_t;

    function automatic arch_t arch_of(line_st_t s);
        case (s)
            LS_S, LS_PRDX_S: arch_of = AR_S;
            LS_M, LS_PWB_M:  arch_of = AR_M;
            default:         arch_of = AR_I;
        endcase
    endfunction

    function automatic logic is_pend(line_st_t s);
        is_pend = (s == LS_PRD_I) || (s == LS_PRDX_I) ||
                  (s == LS_PRDX_S) || (s == LS_PWB_M);
    endfunction

    function automatic act_t cmd_of(line_st_t s);
        case (s)
            LS_PRD_I:             cmd_of = ACT_BUS_RD;
            LS_PRDX_I, LS_PRDX_S: cmd_of = ACT_RDX;
            LS_PWB_M:             cmd_of = ACT_WB;
            default:              cmd_of = ACT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/msi_line_fsm.sv
module msi_line_fsm
    import msi_pkg::*;
(
    input  line_st_t cur,
    input  ev_t      ev,
    output line_st_t nxt,
    output logic     fire,
    output arch_t    from_a,
    output arch_t    to_a,
    output ev_t      rec_ev,
    output act_t     act
);

    always_comb begin
        nxt    = cur;
        act    = ACT_NONE;
        rec_ev = ev;
        unique case (cur)
            LS_I: begin
                case (ev)
                    EV_CPU_RD: nxt = LS_PRD_I;
                    EV_CPU_WR: nxt = LS_PRDX_I;
                    default: ;
                endcase
            end
            LS_S: begin
                case (ev)
                    EV_CPU_WR:              nxt = LS_PRDX_S;
                    EV_CPU_REP, EV_SNP_RDX: nxt = LS_I;
                    default: ;
                endcase
            end
            LS_M: begin
                case (ev)
                    EV_CPU_REP: nxt = LS_PWB_M;
                    EV_SNP_RD: begin
                        nxt = LS_S;
                        act = ACT_SUPPLY;
                    end
                    EV_SNP_RDX: begin
                        nxt = LS_I;
                        act = ACT_SUPPLY;
                    end
                    default: ;
                endcase
            end
            LS_PRD_I: begin
                if (ev == EV_GNT) begin
                    nxt    = LS_S;
                    act    = ACT_BUS_RD;
                    rec_ev = EV_CPU_RD;
                end
            end
            LS_PRDX_I: begin
                if (ev == EV_GNT) begin
                    nxt    = LS_M;
                    act    = ACT_RDX;
                    rec_ev = EV_CPU_WR;
                end
            end
            LS_PRDX_S: begin
                case (ev)
                    EV_SNP_RDX: nxt = LS_PRDX_I;
                    EV_GNT: begin
                        nxt    = LS_M;
                        act    = ACT_RDX;
                        rec_ev = EV_CPU_WR;
                    end
                    default: ;
                endcase
            end
            LS_PWB_M: begin
                case (ev)
                    EV_SNP_RD, EV_SNP_RDX: begin
                        nxt = LS_I;
                        act = ACT_SUPPLY;
                    end
                    EV_GNT: begin
                        nxt    = LS_I;
                        act    = ACT_WB;
                        rec_ev = EV_CPU_REP;
                    end
                    default: ;
                endcase
            end
            default: nxt = LS_I;
        endcase
    end

    assign from_a = arch_of(cur);
    assign to_a   = arch_of(nxt);
    assign fire   = (ev != EV_NONE) && (from_a != to_a);

endmodule

// File: rtl/msi_state_table.sv
module msi_state_table
    import msi_pkg::*;
#(
    parameter int LINES = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_st_t         wr_st,
    input  logic [IDX_W-1:0] rd_a_idx,
    output line_st_t         rd_a_st,
    input  logic [IDX_W-1:0] rd_b_idx,
    output line_st_t         rd_b_st
);

    line_st_t st_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                st_q[g] <= LS_I;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                st_q[g] <= wr_st;
        end
    end

    assign rd_a_st = st_q[rd_a_idx];
    assign rd_b_st = st_q[rd_b_idx];

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int LINES = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    input  logic [1:0]       cpu_op,
    input  logic [IDX_W-1:0] cpu_idx,
    output logic             cpu_ready,
    input  logic             snp_valid,
    input  logic             snp_op,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_supply,
    input  logic             bus_gnt,
    output logic             bus_req,
    output logic [2:0]       bus_cmd,
    output logic [IDX_W-1:0] bus_idx,
    output logic             rec_valid,
    output logic [IDX_W-1:0] rec_idx,
    output logic [1:0]       rec_from,
    output logic [1:0]       rec_to,
    output logic [2:0]       rec_event,
    output logic [2:0]       rec_act
);

    logic             pend_q;
    logic [IDX_W-1:0] pend_idx_q;
    ev_t              ev;
    logic [IDX_W-1:0] ev_idx;
    line_st_t         cur_st, nxt_st, pend_st;
    logic             fire;
    arch_t            from_a, to_a;
    ev_t              rec_ev;
    act_t             act;

    assign cpu_ready = !pend_q && !snp_valid;

    // one event per cycle: snoop, then grant, then processor
    always_comb begin
        ev     = EV_NONE;
        ev_idx = cpu_idx;
        if (snp_valid) begin
            ev     = snp_op ? EV_SNP_RDX : EV_SNP_RD;
            ev_idx = snp_idx;
        end else if (pend_q && bus_gnt) begin
            ev     = EV_GNT;
            ev_idx = pend_idx_q;
        end else if (cpu_valid && cpu_ready) begin
            case (cpu_op)
                2'd0:    ev = EV_CPU_RD;
                2'd1:    ev = EV_CPU_WR;
                2'd2:    ev = EV_CPU_REP;
                default: ev = EV_NONE;
            endcase
        end
    end

    msi_state_table #(.LINES(LINES)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    ((ev != EV_NONE) && (nxt_st != cur_st)),
        .wr_idx   (ev_idx),
        .wr_st    (nxt_st),
        .rd_a_idx (ev_idx),
        .rd_a_st  (cur_st),
        .rd_b_idx (pend_idx_q),
        .rd_b_st  (pend_st)
    );

    msi_line_fsm fsm_i (
        .cur    (cur_st),
        .ev     (ev),
        .nxt    (nxt_st),
        .fire   (fire),
        .from_a (from_a),
        .to_a   (to_a),
        .rec_ev (rec_ev),
        .act    (act)
    );

    // pending-operation register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
        end else if (ev != EV_NONE) begin
            if (!pend_q && is_pend(nxt_st)) begin
                pend_q     <= 1'b1;
                pend_idx_q <= ev_idx;
            end else if (pend_q && (ev_idx == pend_idx_q) && !is_pend(nxt_st)) begin
                pend_q <= 1'b0;
            end
        end
    end

    // registered transition record and supply pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid  <= 1'b0;
            rec_idx    <= '0;
            rec_from   <= 2'd0;
            rec_to     <= 2'd0;
            rec_event  <= 3'd0;
            rec_act    <= 3'd0;
            snp_supply <= 1'b0;
        end else begin
            rec_valid  <= fire;
            snp_supply <= fire && (act == ACT_SUPPLY);
            if (fire) begin
                rec_idx   <= ev_idx;
                rec_from  <= from_a;
                rec_to    <= to_a;
                rec_event <= rec_ev;
                rec_act   <= act;
            end
        end
    end

    assign bus_req = pend_q;
    assign bus_idx = pend_idx_q;
    assign bus_cmd = pend_q ? cmd_of(pend_st) : ACT_NONE;

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk
    import msi_pkg::*;
#(
    parameter int LINES = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ready,
    input logic             snp_valid,
    input logic [IDX_W-1:0] snp_idx,
    input logic             snp_supply,
    input logic             bus_gnt,
    input logic             bus_req,
    input logic [2:0]       bus_cmd,
    input logic [IDX_W-1:0] bus_idx,
    input logic             rec_valid,
    input logic [1:0]       rec_from,
    input logic [1:0]       rec_to,
    input logic [2:0]       rec_act
);

    AST_STALL_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_ready); // R11

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt && !(snp_valid && snp_idx == bus_idx)
        |=> bus_req && $stable(bus_idx) && $stable(bus_cmd)); // R11

    AST_GNT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt && !snp_valid
        |=> rec_valid && (rec_act == $past(bus_cmd)) && !bus_req); // R2

    AST_SNP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> !(rec_valid && (rec_act == ACT_BUS_RD || rec_act == ACT_RDX ||
                                      rec_act == ACT_WB))); // R12

    AST_SUPPLY_M: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> rec_valid && (rec_from == AR_M) && (rec_act == ACT_SUPPLY)); // R9

    AST_REC_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_from != rec_to)); // R13

    AST_WB_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && (rec_act == ACT_WB) |-> (rec_from == AR_M) && (rec_to == AR_I)); // R6

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.LINES(LINES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_ready  (cpu_ready),
    .snp_valid  (snp_valid),
    .snp_idx    (snp_idx),
    .snp_supply (snp_supply),
    .bus_gnt    (bus_gnt),
    .bus_req    (bus_req),
    .bus_cmd    (bus_cmd),
    .bus_idx    (bus_idx),
    .rec_valid  (rec_valid),
    .rec_from   (rec_from),
    .rec_to     (rec_to),
    .rec_act    (rec_act)
);

// File: tb/msi_snoop_ctrl_tb_top.sv
module msi_snoop_ctrl_tb_top;

    localparam int LINES = 4;
    localparam int IW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_valid = 1'b0;
    logic [1:0]    cpu_op = 2'd0;
    logic [IW-1:0] cpu_idx = '0;
    logic          cpu_ready;
    logic          snp_valid = 1'b0;
    logic          snp_op = 1'b0;
    logic [IW-1:0] snp_idx = '0;
    logic          snp_supply;
    logic          bus_gnt = 1'b0;
    logic          bus_req;
    logic [2:0]    bus_cmd;
    logic [IW-1:0] bus_idx;
    logic          rec_valid;
    logic [IW-1:0] rec_idx;
    logic [1:0]    rec_from, rec_to;
    logic [2:0]    rec_event, rec_act;

    always #5 clk = ~clk;

    msi_snoop_ctrl #(.LINES(LINES)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_idx(cpu_idx), .cpu_ready(cpu_ready),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_idx(snp_idx), .snp_supply(snp_supply),
        .bus_gnt(bus_gnt), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_idx(bus_idx),
        .rec_valid(rec_valid), .rec_idx(rec_idx), .rec_from(rec_from), .rec_to(rec_to),
        .rec_event(rec_event), .rec_act(rec_act)
    );

    typedef struct packed {
        logic [IW-1:0] idx;
        logic [1:0]    from;
        logic [1:0]    to;
        logic [2:0]    ev;
        logic [2:0]    act;
    } exp_t;

    exp_t  expq [$];
    string tagq [$];
    int    total = 0;
    int    bad   = 0;

    task automatic chk_eq(string tag, string what, int actual, int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, actual, expected);
        end
    endtask

    task automatic expect_rec(string tag, int idx, int from, int to, int ev, int act);
        expq.push_back({IW'(idx), 2'(from), 2'(to), 3'(ev), 3'(act)});
        tagq.push_back(tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rec_valid) begin
            total++;
            if (expq.size() == 0) begin
                bad++;
                $display("FAIL R10 unexpected record actual=%0h expected=none",
                         {rec_idx, rec_from, rec_to, rec_event, rec_act});
            end else begin
                exp_t  e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                if ({rec_idx, rec_from, rec_to, rec_event, rec_act} != e) begin
                    bad++;
                    $display("FAIL %s record actual=%0h expected=%0h", t,
                             {rec_idx, rec_from, rec_to, rec_event, rec_act}, e);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cpu_req(int op, int idx);
        cpu_valid = 1'b1; cpu_op = 2'(op); cpu_idx = IW'(idx);
        tick();
        cpu_valid = 1'b0;
    endtask

    task automatic snoop(int op, int idx);
        snp_valid = 1'b1; snp_op = 1'(op); snp_idx = IW'(idx);
        tick();
        snp_valid = 1'b0;
    endtask

    task automatic grant();
        bus_gnt = 1'b1;
        tick();
        bus_gnt = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk_eq("R1", "cpu_ready", int'(cpu_ready), 1);
        chk_eq("R1", "bus_req", int'(bus_req), 0);
        chk_eq("R1", "rec_valid", int'(rec_valid), 0);
        chk_eq("R1", "snp_supply", int'(snp_supply), 0);

        // FILL_S with a stalled request in between
        cpu_req(0, 1);
        chk_eq("R2", "bus_req", int'(bus_req), 1);
        chk_eq("R2", "bus_cmd", int'(bus_cmd), 1);
        chk_eq("R2", "bus_idx", int'(bus_idx), 1);
        chk_eq("R11", "cpu_ready pending", int'(cpu_ready), 0);
        cpu_req(1, 2);
        chk_eq("R11", "bus_idx held", int'(bus_idx), 1);
        chk_eq("R11", "bus_cmd held", int'(bus_cmd), 1);
        expect_rec("R2", 1, 0, 1, 1, 1);
        grant();
        chk_eq("R2", "bus_req after grant", int'(bus_req), 0);
        tick();
        chk_eq("R13", "rec_valid one cycle", int'(rec_valid), 0);

        // hit: no record
        cpu_req(0, 1);
        chk_eq("R10", "bus_req on hit", int'(bus_req), 0);

        // UPGRADE, then lost to snooped read-exclusive
        cpu_req(1, 1);
        chk_eq("R4", "bus_cmd upgrade", int'(bus_cmd), 2);
        snoop(0, 1);
        chk_eq("R5", "bus_req after snoop read", int'(bus_req), 1);
        expect_rec("R5", 1, 1, 0, 5, 0);
        snoop(1, 1);
        chk_eq("R5", "bus_cmd after lost upgrade", int'(bus_cmd), 2);
        expect_rec("R5", 1, 0, 2, 2, 2);
        grant();

        // DEMOTE, UPGRADE, KILL_M
        expect_rec("R9", 1, 2, 1, 4, 4);
        snoop(0, 1);
        chk_eq("R9", "snp_supply demote", int'(snp_supply), 1);
        cpu_req(1, 1);
        chk_eq("R4", "bus_cmd", int'(bus_cmd), 2);
        expect_rec("R4", 1, 1, 2, 2, 2);
        grant();
        expect_rec("R9", 1, 2, 0, 5, 4);
        snoop(1, 1);
        chk_eq("R9", "snp_supply kill", int'(snp_supply), 1);

        // FILL_M, then EVICT_M with a snoop/grant collision
        cpu_req(1, 2);
        chk_eq("R3", "bus_cmd", int'(bus_cmd), 2);
        expect_rec("R3", 2, 0, 2, 2, 2);
        grant();
        cpu_req(0, 2);
        cpu_req(1, 2);
        chk_eq("R10", "bus_req on M hit", int'(bus_req), 0);
        cpu_req(2, 2);
        chk_eq("R6", "bus_cmd writeback", int'(bus_cmd), 3);
        bus_gnt = 1'b1;
        snoop(0, 3);
        bus_gnt = 1'b0;
        chk_eq("R12", "bus_req after ignored grant", int'(bus_req), 1);
        expect_rec("R6", 2, 2, 0, 3, 3);
        grant();

        // DROP_S by replace and by snoop
        cpu_req(0, 0);
        expect_rec("R2", 0, 0, 1, 1, 1);
        grant();
        expect_rec("R8", 0, 1, 0, 3, 0);
        cpu_req(2, 0);
        chk_eq("R8", "no bus_req on replace S", int'(bus_req), 0);
        cpu_req(0, 0);
        expect_rec("R2", 0, 0, 1, 1, 1);
        grant();
        expect_rec("R8", 0, 1, 0, 5, 0);
        snoop(1, 0);

        // EVICT_SNOOPED
        cpu_req(1, 3);
        expect_rec("R3", 3, 0, 2, 2, 2);
        grant();
        cpu_req(2, 3);
        expect_rec("R7", 3, 2, 0, 4, 4);
        snoop(0, 3);
        chk_eq("R7", "bus_req cleared", int'(bus_req), 0);
        chk_eq("R7", "snp_supply", int'(snp_supply), 1);
        grant();
        chk_eq("R7", "rec_valid after stray grant", int'(rec_valid), 0);

        // snoop to pending fill from Invalid
        cpu_req(0, 2);
        snoop(1, 2);
        chk_eq("R10", "bus_cmd kept", int'(bus_cmd), 1);
        expect_rec("R2", 2, 0, 1, 1, 1);
        grant();

        // ready low during snoop
        snp_valid = 1'b1; snp_op = 1'b0; snp_idx = 2'd3;
        #1;
        chk_eq("R11", "cpu_ready with snoop", int'(cpu_ready), 0);
        tick();
        snp_valid = 1'b0;

        // snoop and grant together on the pending line
        cpu_req(1, 0);
        bus_gnt = 1'b1;
        snoop(0, 0);
        bus_gnt = 1'b0;
        chk_eq("R12", "bus_req kept", int'(bus_req), 1);
        expect_rec("R3", 0, 0, 2, 2, 2);
        grant();

        repeat (3) tick();
        chk_eq("R13", "outstanding expectations", expq.size(), 0);
        finish_run();
    end

endmodule